// File: doc/BRIEF.md
# Direct Digital Synthesis Waveform Generator

This block is a numerically controlled oscillator. A wide phase accumulator advances by a programmable tuning word on every cycle in which the sample-rate enable (`tick`) is high and the generator is enabled. The top bits of the accumulator form a table index. A separate phase-offset word is added to that index, and the sum reads one entry of a power-of-two waveform table. The entry read is registered as the output sample and comes with a one-cycle valid pulse.

The output frequency is `tune * f_tick / 2^ACC_W`. The table depth does not change it. A tuning word larger than one table step makes the generator skip entries. A smaller one makes entries repeat. The phase offset acts only on the table index, never on the accumulator. It can therefore be changed for phase-shift modulation without disturbing frequency or phase continuity. New tuning and offset values are captured by a load strobe and take effect from the next tick. The waveform is loaded through a write port, which only accepts writes while the generator is disabled.

Top module: `dds_nco`

## Requirements
- R1: After reset, `samp_out` is 0, `samp_valid` is 0, and the accumulator, tuning word and phase offset are 0. The first enabled tick after reset therefore reads table entry 0.
- R2: On each enabled tick (`tick` and `run_en` both high), the accumulator grows by the active tuning word. Successive samples follow the table at stride `tune / 2^(ACC_W-ADDR_W)` entries, so large words skip entries and small words repeat them.
- R3: An enabled tick reads table index `(acc[ACC_W-1 -: ADDR_W] + phase) mod 2^ADDR_W`. The accumulator value used is the one held before that tick's addition.
- R4: `samp_valid` is high for exactly one cycle in the cycle after each enabled tick, and `samp_out` carries the entry read in that same cycle. Without an enabled tick, `samp_valid` stays low.
- R5: A `cfg_load` pulse captures `cfg_tune` and `cfg_phase`, and every later tick uses them. If a tick happens in the same cycle as a load, that tick still uses the previous values.
- R6: A load never changes the accumulator. Phase continues from where it was.
- R7: While `run_en` is low, ticks are ignored: no valid pulse is produced and the accumulator holds its value.
- R8: A table write (`tbl_wr_en`) stores `tbl_wr_data` at `tbl_wr_addr` only while `run_en` is low. A write attempted while `run_en` is high leaves the table unchanged.
- R9: The accumulator wraps modulo 2^ACC_W.
- R10: Between valid pulses, `samp_out` holds the last sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Generator enable; table writable only when low |
| tick | input | 1 | Sample-rate enable |
| cfg_load | input | 1 | Captures cfg_tune and cfg_phase |
| cfg_tune | input | ACC_W (32) | Tuning word |
| cfg_phase | input | ADDR_W (10) | Phase offset added to the table index |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_addr | input | ADDR_W (10) | Table write index |
| tbl_wr_data | input | SAMP_W (12) | Table write data |
| samp_out | output | SAMP_W (12) | Registered sample |
| samp_valid | output | 1 | One-cycle pulse marking a new sample |

## Verification
The hardest case to reach from the ports is a table write attempted while the generator runs. The write cannot be observed directly, so the stimulus sets the tuning word to zero. It then loads a phase offset chosen from the modelled accumulator so that the next tick reads exactly the attacked index, and the sample must still show the old entry. Accumulator wrap is reached by a tuning word of three quarters of full scale. A load coincident with a tick, and ticks while disabled, are driven mid-stream. Continuity of the following samples then shows whether the accumulator was touched.

// File: rtl/dds_pkg.sv
package dds_pkg;
    localparam int DDS_ACC_W  = 32;
    localparam int DDS_ADDR_W = 10;
    localparam int DDS_SAMP_W = 12;
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc
    import dds_pkg::*;
#(
    parameter int ACC_W  = DDS_ACC_W,
    parameter int ADDR_W = DDS_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              load,
    input  logic [ACC_W-1:0]  tune_in,
    input  logic [ADDR_W-1:0] phase_in,
    output logic [ACC_W-1:0]  acc_o,
    output logic [ADDR_W-1:0] phase_o
);
    typedef struct packed {
        logic [ACC_W-1:0]  acc;
        logic [ACC_W-1:0]  tune;
        logic [ADDR_W-1:0] phase;
    } acc_state_t;

    acc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (advance) begin
            st_d.acc = st_q.acc + st_q.tune;
        end
        if (load) begin
            st_d.tune  = tune_in;
            st_d.phase = phase_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o   = st_q.acc;
    assign phase_o = st_q.phase;

    // R7 / R6: without an enabled tick the accumulator does not move
    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(acc_o));
    // R6: a load alone leaves the phase unchanged
    assert_load_keeps_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !advance) |=> (acc_o == $past(acc_o)));
    // R5: offset presented on a load is the one held afterwards
    assert_offset_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (phase_o == $past(phase_in)));
endmodule

// File: rtl/dds_addr_map.sv
module dds_addr_map
    import dds_pkg::*;
#(
    parameter int ACC_W  = DDS_ACC_W,
    parameter int ADDR_W = DDS_ADDR_W
) (
    input  logic [ACC_W-1:0]  acc,
    input  logic [ADDR_W-1:0] phase,
    output logic [ADDR_W-1:0] index
);
    localparam int TOP_LSB = ACC_W - ADDR_W;

    logic [ADDR_W-1:0] coarse;

    always_comb begin
        coarse = acc[ACC_W-1:TOP_LSB];
        index  = coarse + phase;
    end
endmodule

// File: rtl/dds_wave_table.sv
module dds_wave_table
    import dds_pkg::*;
#(
    parameter int ADDR_W = DDS_ADDR_W,
    parameter int SAMP_W = DDS_SAMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              locked,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SAMP_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [SAMP_W-1:0] samp_o,
    output logic              valid_o
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [SAMP_W-1:0] samp;
        logic              valid;
    } out_state_t;

    logic [SAMP_W-1:0] mem_q [DEPTH];
    out_state_t        out_d, out_q;
    logic              wr_ok;

    assign wr_ok = wr_en && !locked;

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        out_d       = out_q;
        out_d.valid = rd_en;
        if (rd_en) begin
            out_d.samp = mem_q[rd_addr];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign samp_o  = out_q.samp;
    assign valid_o = out_q.valid;

    // R4: one valid pulse per read, in the following cycle
    assert_valid_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> valid_o);
    assert_no_spurious_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !valid_o);
    // R10: output holds between reads
    assert_sample_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(samp_o));
endmodule

// File: rtl/dds_nco.sv
module dds_nco
    import dds_pkg::*;
#(
    parameter int ACC_W  = DDS_ACC_W,
    parameter int ADDR_W = DDS_ADDR_W,
    parameter int SAMP_W = DDS_SAMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              tick,
    input  logic              cfg_load,
    input  logic [ACC_W-1:0]  cfg_tune,
    input  logic [ADDR_W-1:0] cfg_phase,
    input  logic              tbl_wr_en,
    input  logic [ADDR_W-1:0] tbl_wr_addr,
    input  logic [SAMP_W-1:0] tbl_wr_data,
    output logic [SAMP_W-1:0] samp_out,
    output logic              samp_valid
);
    logic              advance;
    logic [ACC_W-1:0]  acc;
    logic [ADDR_W-1:0] phase;
    logic [ADDR_W-1:0] index;

    assign advance = tick && run_en;

    dds_phase_acc #(.ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (advance),
        .load     (cfg_load),
        .tune_in  (cfg_tune),
        .phase_in (cfg_phase),
        .acc_o    (acc),
        .phase_o  (phase)
    );

    dds_addr_map #(.ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_map (
        .acc   (acc),
        .phase (phase),
        .index (index)
    );

    dds_wave_table #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .locked  (run_en),
        .wr_en   (tbl_wr_en),
        .wr_addr (tbl_wr_addr),
        .wr_data (tbl_wr_data),
        .rd_en   (advance),
        .rd_addr (index),
        .samp_o  (samp_out),
        .valid_o (samp_valid)
    );

    // R7: a tick while disabled yields no sample
    assert_disabled_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !samp_valid);
endmodule

// File: tb/dds_nco_tb_top.sv
module dds_nco_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ACC_W  = 32;
    localparam int ADDR_W = 10;
    localparam int SAMP_W = 12;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              run_en = 1'b0;
    logic              tick = 1'b0;
    logic              cfg_load = 1'b0;
    logic [ACC_W-1:0]  cfg_tune = '0;
    logic [ADDR_W-1:0] cfg_phase = '0;
    logic              tbl_wr_en = 1'b0;
    logic [ADDR_W-1:0] tbl_wr_addr = '0;
    logic [SAMP_W-1:0] tbl_wr_data = '0;
    logic [SAMP_W-1:0] samp_out;
    logic              samp_valid;

    always #(CLK_PERIOD/2) clk = ~clk;

    dds_nco #(.ACC_W(ACC_W), .ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick),
        .cfg_load(cfg_load), .cfg_tune(cfg_tune), .cfg_phase(cfg_phase),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data),
        .samp_out(samp_out), .samp_valid(samp_valid)
    );

    // reference state built from the requirements
    logic [SAMP_W-1:0] tbl_m [DEPTH];
    logic [ACC_W-1:0]  acc_m = '0;
    logic [ACC_W-1:0]  tune_m = '0;
    logic [ADDR_W-1:0] ph_m = '0;

    logic [SAMP_W-1:0] exp_q [$];
    string             tag_q [$];
    int                n_chk = 0;
    int                n_fail = 0;
    logic [SAMP_W-1:0] last_samp = '0;
    bit                mon_on = 1'b0;
    bit                done = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input bit t, input bit ld, input logic [ACC_W-1:0] tw,
                         input logic [ADDR_W-1:0] ph, input string tag);
        logic [ADDR_W-1:0] idx;
        @(posedge clk); #1;
        tick = t; cfg_load = ld; cfg_tune = tw; cfg_phase = ph; tbl_wr_en = 1'b0;
        if (t && run_en) begin
            idx = acc_m[ACC_W-1 -: ADDR_W] + ph_m;
            exp_q.push_back(tbl_m[idx]);
            tag_q.push_back(tag);
            acc_m = acc_m + tune_m;
        end
        if (ld) begin
            tune_m = tw;
            ph_m = ph;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, '0, '0, "");
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) drive(1'b1, 1'b0, '0, '0, tag);
    endtask

    task automatic load(input logic [ACC_W-1:0] tw, input logic [ADDR_W-1:0] ph);
        drive(1'b0, 1'b1, tw, ph, "");
    endtask

    task automatic set_run(input bit r);
        @(posedge clk); #1;
        tick = 1'b0; cfg_load = 1'b0; tbl_wr_en = 1'b0; run_en = r;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [SAMP_W-1:0] d);
        @(posedge clk); #1;
        tick = 1'b0; cfg_load = 1'b0;
        tbl_wr_en = 1'b1; tbl_wr_addr = a; tbl_wr_data = d;
        if (!run_en) tbl_m[a] = d;
    endtask

    // monitor: pops expected samples as the design produces them
    always @(negedge clk) begin
        if (mon_on && !done) begin
            if (samp_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4", "valid with no pending tick", 1, 0);
                end else begin
                    logic [SAMP_W-1:0] e;
                    string tg;
                    e = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    check(samp_out == e, tg, "sample", samp_out, e);
                    last_samp = samp_out;
                end
            end else begin
                check(samp_out == last_samp, "R10", "held sample", samp_out, last_samp);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [ADDR_W-1:0] ph_sel;
        logic [SAMP_W-1:0] orig;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(samp_out == '0, "R1", "reset sample", samp_out, 0);
        check(samp_valid == 1'b0, "R1", "reset valid", samp_valid, 0);
        @(posedge clk); #1; rst_n = 1'b1;
        mon_on = 1'b1;

        // R8: load table while disabled
        for (int i = 0; i < DEPTH; i++) wr(i[ADDR_W-1:0], SAMP_W'((i * 37 + 5) ^ (i >> 3)));
        idle(1);

        // R7: ticks while disabled do nothing
        ticks(3, "R7");
        @(negedge clk);
        check(samp_valid == 1'b0, "R7", "valid while disabled", samp_valid, 0);

        set_run(1'b1);
        // R1: first tick reads entry 0
        ticks(1, "R1");
        idle(2);

        // R2: unit stride, skipping, repeating
        load(32'h0040_0000, '0);
        ticks(6, "R2");
        load(32'h00C0_0000, '0);
        ticks(5, "R2");
        load(32'h0010_0000, '0);
        ticks(8, "R2");
        idle(1);

        // R5: load coincident with a tick uses old values for that tick
        drive(1'b1, 1'b1, 32'h0080_0000, 10'd100, "R5");
        ticks(4, "R3");

        // R3: offset crossing the table end wraps the index
        load(32'h0080_0000, 10'd1000);
        ticks(5, "R3");

        // R6: idle load mid-run keeps phase continuous
        idle(2);
        load(32'h0040_0000, 10'd3);
        idle(1);
        ticks(4, "R6");

        // R9: accumulator wrap
        load(32'hC000_0000, '0);
        ticks(6, "R9");

        // R2: odd tuning word, sparse and back-to-back ticks
        load(32'h1234_5679, 10'd7);
        for (int i = 0; i < 10; i++) begin
            ticks(1, "R2");
            if (i % 3 == 0) idle(2);
        end

        // R8: write while running is ignored
        orig = tbl_m[77];
        wr(10'd77, ~orig);
        idle(1);
        ph_sel = 10'd77 - acc_m[ACC_W-1 -: ADDR_W];
        load('0, ph_sel);
        ticks(2, "R8");
        idle(2);
        @(negedge clk);
        check(last_samp == orig, "R8", "entry after locked write", last_samp, orig);

        // R7: disabled ticks, then continuity after re-enable
        set_run(1'b0);
        ticks(4, "R7");
        @(negedge clk);
        check(samp_valid == 1'b0, "R7", "valid while disabled", samp_valid, 0);
        // R8: write while disabled takes effect
        wr(10'd77, 12'h5A5);
        idle(1);
        set_run(1'b1);
        ticks(1, "R8");
        load(32'h0040_0000, ph_sel);
        ticks(3, "R7");
        idle(3);

        @(negedge clk);
        check(exp_q.size() == 0, "R4", "pending samples at end", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule